// File: doc/BRIEF.md
# UART Line-Control Busy-Write Guard

This block is the register front end of a 16550-style serial port. It holds the line control byte and refuses to change it while the serial engine reports activity. A line-control write that arrives while the engine is busy is discarded. Instead, a sticky busy-detect event is latched and raises the interrupt line. Software reads the status register to clear the event. It then drops the engine to idle by clearing the FIFOs and draining the receive buffer, and writes the line control byte again.

Besides the busy guard, the block decodes the ordinary 16550 register set at a configurable address stride. It reports a prioritised interrupt identity and masks the modem status while automatic flow control is on. It also exposes a read-only capability word and a version word built from parameters. The baud generator, shift registers and FIFOs are not part of the block. They are represented only by a busy input, FIFO level inputs, a receive byte input and strobe outputs.

Top module: `uart_lcr_guard`

## Requirements
- R1: A write to the line control register (register index 3) while `busy` is high leaves the stored line control value unchanged.
- R2: Such a rejected write sets a busy-detect latch on the next clock. While the latch is set, `irq` is high, and the identity register (index 2) reads 0x7 in bits [3:0] when no other source is pending.
- R3: A read of the status register (register index 0x1F) returns the live `busy` input in bit 0 and zeros above it. That read clears the busy-detect latch and has no other effect.
- R4: A line control write while `busy` is low takes effect on the next clock, and a read back returns exactly the written byte.
- R5: The identity field in bits [3:0] follows a fixed priority. Received data enabled by interrupt-enable bit 0 gives 0x4. Transmit empty enabled by bit 1 gives 0x2. Busy-detect gives 0x7. No pending source gives 0x1. `irq` is high exactly when the field is not 0x1.
- R6: The recovery path is driven by strobes. A write to index 2 with bit 1 or bit 2 set pulses `fifo_clr` during that write. A read of index 0 pulses `rx_pop` and returns `rx_byte`. A write to index 0 pulses `tx_push`, with the byte on `tx_data`.
- R7: The capability word sits at byte address 0xF4. It carries the bus-width code in [1:0] and the FIFO depth divided by 16 in [23:16]. Option flags are set from parameters: extra DMA signals bit 13, encoded parameters 12, shadow registers 11, FIFO status 10, FIFO access 9, extended features 8, infrared low-power 7, infrared 6, transmit-empty mode 5, auto flow control 4.
- R8: The version word sits at byte address 0xF8 and returns the version parameter. When the extended-features parameter is off, both the version word and the capability word read zero.
- R9: The modem status register (index 6) places the sampled CTS in bit 4 and its change flag in bit 0. When auto flow control is configured and modem control bit 5 is set, bit 4 reads 1 and bit 0 reads 0. A read of the register clears all change flags.
- R10: Register index n decodes only at byte address n shifted left by `ADDR_SHIFT`. A byte address with nonzero bits below the shift selects no register: a write there changes nothing, and a read returns 0.
- R11: After reset the line control value is 0x00, the busy-detect latch is clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered at the edge that ends the read |
| busy | input | 1 | Serial engine activity |
| rx_avail | input | 1 | Receive FIFO holds data (stub level) |
| tx_empty | input | 1 | Transmit FIFO empty (stub level) |
| rx_byte | input | 8 | Head byte of the receive FIFO |
| modem_in | input | 4 | Modem lines {DCD, RI, DSR, CTS}, active high |
| tx_push | output | 1 | Pulse on a transmit holding write |
| tx_data | output | 8 | Byte pushed with `tx_push` |
| rx_pop | output | 1 | Pulse on a receive buffer read |
| fifo_clr | output | 1 | Pulse on a FIFO-clear write |
| irq | output | 1 | Interrupt request |

## Verification
Line-control writes are tried with the engine idle and with it busy. A busy write must leave the earlier value while latching the event, and an idle write must land on the very next cycle. The identity priority is walked through overlapping sources: received data with transmit-empty, transmit-empty with busy-detect, and busy-detect alone. This shows that busy-detect only surfaces once the standard sources are quiet. A second instance with zero address shift and extended features off separates aligned from unaligned decoding, and parameter-driven words from forced zeros. CTS toggles are read with and without the auto-flow bit, so that masking is distinguished from clear-on-read.

// File: rtl/uart_lcr_guard.sv
module uart_lcr_guard #(
  parameter int          ADDR_W          = 8,
  parameter int          ADDR_SHIFT      = 2,
  parameter int          FIFO_DEPTH      = 64,
  parameter bit          HAS_EXTRAS      = 1'b1,
  parameter bit          HAS_AUTOFLOW    = 1'b1,
  parameter bit          HAS_THRE_MODE   = 1'b1,
  parameter bit          HAS_IRDA        = 1'b0,
  parameter bit          HAS_IRDA_LP     = 1'b0,
  parameter bit          HAS_FIFO_ACCESS = 1'b0,
  parameter bit          HAS_FIFO_STATUS = 1'b1,
  parameter bit          HAS_SHADOW      = 1'b1,
  parameter bit          HAS_ENC_PARAMS  = 1'b1,
  parameter bit          HAS_DMA_EXTRA   = 1'b1,
  parameter logic [1:0]  BUS_CODE        = 2'd2,
  parameter logic [31:0] VERSION         = 32'h3430_312a
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              rx_avail,
  input  logic              tx_empty,
  input  logic [7:0]        rx_byte,
  input  logic [3:0]        modem_in,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic              rx_pop,
  output logic              fifo_clr,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((1 << ADDR_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] CAP_ADDR  = ADDR_W'(8'hf4);
  localparam logic [ADDR_W-1:0] VER_ADDR  = ADDR_W'(8'hf8);
  localparam logic [7:0]        FIFO_CODE = 8'(FIFO_DEPTH / 16);
  localparam logic [31:0] CAP_RAW = {8'h00, FIFO_CODE, 2'b00,
                                     HAS_DMA_EXTRA, HAS_ENC_PARAMS, HAS_SHADOW,
                                     HAS_FIFO_STATUS, HAS_FIFO_ACCESS, HAS_EXTRAS,
                                     HAS_IRDA_LP, HAS_IRDA, HAS_THRE_MODE,
                                     HAS_AUTOFLOW, 2'b00, BUS_CODE};
  localparam logic [31:0] CAP_WORD = HAS_EXTRAS ? CAP_RAW : 32'h0;
  localparam logic [31:0] VER_WORD = HAS_EXTRAS ? VERSION : 32'h0;
  localparam bit          FIFO_OK  = FIFO_DEPTH > 0;

  logic              aligned;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        sel;
  logic              sel_usr;

  assign aligned = (addr & LANE_MASK) == '0;
  assign idx     = addr >> ADDR_SHIFT;
  assign sel_usr = aligned && idx == ADDR_W'(31);

  always_comb
    for (int i = 0; i < 8; i++) sel[i] = aligned && idx == ADDR_W'(i);

  logic [7:0] lcr_q, scr_q;
  logic [5:0] mcr_q;
  logic [1:0] ier_q;
  logic       fifo_en_q;
  logic       busy_det_q;
  logic [3:0] mdm_q, dlt_q;

  logic lcr_wr, usr_rd, msr_rd;
  assign lcr_wr = wr_en && sel[3];
  assign usr_rd = rd_en && sel_usr;
  assign msr_rd = rd_en && sel[6];

  assign tx_push  = wr_en && sel[0];
  assign tx_data  = wdata[7:0];
  assign rx_pop   = rd_en && sel[0];
  assign fifo_clr = wr_en && sel[2] && (wdata[1] || wdata[2]);

  logic [3:0] dlt_evt;
  assign dlt_evt = {modem_in[3] ^ mdm_q[3],
                    mdm_q[2] & ~modem_in[2],
                    modem_in[1] ^ mdm_q[1],
                    modem_in[0] ^ mdm_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q      <= 8'h00;
      scr_q      <= 8'h00;
      mcr_q      <= 6'h00;
      ier_q      <= 2'b00;
      fifo_en_q  <= 1'b0;
      busy_det_q <= 1'b0;
      mdm_q      <= 4'h0;
      dlt_q      <= 4'h0;
    end else begin
      if (lcr_wr && !busy)        lcr_q     <= wdata[7:0];
      if (wr_en && sel[1])        ier_q     <= wdata[1:0];
      if (wr_en && sel[2])        fifo_en_q <= wdata[0];
      if (wr_en && sel[4])        mcr_q     <= wdata[5:0];
      if (wr_en && sel[7])        scr_q     <= wdata[7:0];
      busy_det_q <= (lcr_wr && busy) || (busy_det_q && !usr_rd);
      mdm_q      <= modem_in;
      dlt_q      <= (msr_rd ? 4'h0 : dlt_q) | dlt_evt;
    end
  end

  logic [3:0] iid;
  always_comb begin
    if (ier_q[0] && rx_avail)      iid = 4'h4;
    else if (ier_q[1] && tx_empty) iid = 4'h2;
    else if (busy_det_q)           iid = 4'h7;
    else                           iid = 4'h1;
  end
  assign irq = iid != 4'h1;

  logic afe;
  logic [7:0] msr;
  assign afe = HAS_AUTOFLOW && mcr_q[5];
  assign msr = {mdm_q[3], mdm_q[2], mdm_q[1], afe | mdm_q[0],
                dlt_q[3], dlt_q[2], dlt_q[1], dlt_q[0] & ~afe};

  logic [7:0] lsr;
  assign lsr = {1'b0, tx_empty & ~busy, tx_empty, 4'b0000, rx_avail};

  logic [31:0] rd_val;
  always_comb begin
    rd_val = 32'h0;
    if (addr == CAP_ADDR)      rd_val = CAP_WORD;
    else if (addr == VER_ADDR) rd_val = VER_WORD;
    else if (sel_usr)          rd_val = {31'h0, busy};
    else if (sel[0])           rd_val = {24'h0, rx_byte};
    else if (sel[1])           rd_val = {30'h0, ier_q};
    else if (sel[2])           rd_val = {24'h0, {2{fifo_en_q & FIFO_OK}}, 2'b00, iid};
    else if (sel[3])           rd_val = {24'h0, lcr_q};
    else if (sel[4])           rd_val = {26'h0, mcr_q};
    else if (sel[5])           rd_val = {24'h0, lsr};
    else if (sel[6])           rd_val = {24'h0, msr};
    else if (sel[7])           rd_val = {24'h0, scr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 32'h0;
    else if (rd_en) rdata <= rd_val;
  end

endmodule

// File: rtl/uart_lcr_guard_chk.sv
module uart_lcr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lcr_wr,
  input logic        usr_rd,
  input logic        busy,
  input logic [31:0] wdata,
  input logic [7:0]  lcr_q,
  input logic        busy_det_q,
  input logic        irq
);

  a_r1_lcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr && busy |=> $stable(lcr_q));

  a_r2_det_set: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr && busy |=> busy_det_q);

  a_r2_det_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_det_q) |-> $past(lcr_wr && busy));

  a_r2_irq_up: assert property (@(posedge clk) disable iff (!rst_n)
    busy_det_q |-> irq);

  a_r3_usr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rd && !(lcr_wr && busy) |=> !busy_det_q);

  a_r4_lcr_load: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr && !busy |=> lcr_q == $past(wdata[7:0]));

endmodule

bind uart_lcr_guard uart_lcr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lcr_wr(lcr_wr), .usr_rd(usr_rd), .busy(busy),
  .wdata(wdata), .lcr_q(lcr_q), .busy_det_q(busy_det_q), .irq(irq)
);

// File: tb/uart_lcr_guard_tb.sv
module uart_lcr_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic        busy = 1'b0, rx_avail = 1'b0, tx_empty = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [3:0]  modem_in = 4'h0;

  logic [31:0] rdata, rdata_nf;
  logic        tx_push, rx_pop, fifo_clr, irq;
  logic [7:0]  tx_data;
  logic        tx_push_nf, rx_pop_nf, fifo_clr_nf, irq_nf;
  logic [7:0]  tx_data_nf;

  int total = 0, failed = 0;

  always #10 clk = ~clk;

  uart_lcr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .busy(busy), .rx_avail(rx_avail),
    .tx_empty(tx_empty), .rx_byte(rx_byte), .modem_in(modem_in),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
    .fifo_clr(fifo_clr), .irq(irq));

  uart_lcr_guard #(.ADDR_SHIFT(0), .HAS_EXTRAS(1'b0)) u_dut_nf (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_nf), .busy(busy), .rx_avail(rx_avail),
    .tx_empty(tx_empty), .rx_byte(rx_byte), .modem_in(modem_in),
    .tx_push(tx_push_nf), .tx_data(tx_data_nf), .rx_pop(rx_pop_nf),
    .fifo_clr(fifo_clr_nf), .irq(irq_nf));

  localparam logic [7:0] A_RBR = 8'h00, A_IER = 8'h04, A_IIR = 8'h08,
                         A_LCR = 8'h0c, A_MCR = 8'h10, A_MSR = 8'h18,
                         A_USR = 8'h7c, A_CAP = 8'hf4, A_VER = 8'hf8;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; addr = 8'h00; d = rdata; dn = rdata_nf;
  endtask

  task automatic t_reset;
    logic [31:0] d, dn;
    chk("R11 irq after reset", {31'h0, irq}, 32'h0);
    bus_rd(A_LCR, d, dn);
    chk("R11 line control after reset", d, 32'h00);
    bus_rd(A_IIR, d, dn);
    chk("R11 identity idle after reset", d, 32'h01);
  endtask

  task automatic t_idle_write;
    logic [31:0] d, dn;
    bus_wr(A_LCR, 32'h1b);
    bus_rd(A_LCR, d, dn);
    chk("R4 idle write lands", d, 32'h1b);
    bus_wr(A_LCR, 32'h83);
    bus_rd(A_LCR, d, dn);
    chk("R4 idle write exact", d, 32'h83);
  endtask

  task automatic t_busy_write;
    logic [31:0] d, dn;
    busy = 1'b1;
    bus_wr(A_LCR, 32'h03);
    chk("R2 irq after busy write", {31'h0, irq}, 32'h1);
    bus_rd(A_LCR, d, dn);
    chk("R1 busy write ignored", d, 32'h83);
    bus_rd(A_IIR, d, dn);
    chk("R2 identity busy-detect", d & 32'hf, 32'h7);
  endtask

  task automatic t_usr_clear;
    logic [31:0] d, dn;
    bus_rd(A_USR, d, dn);
    chk("R3 status shows busy", d, 32'h1);
    chk("R3 irq cleared by status read", {31'h0, irq}, 32'h0);
    bus_rd(A_IIR, d, dn);
    chk("R3 identity idle after clear", d & 32'hf, 32'h1);
    bus_rd(A_LCR, d, dn);
    chk("R3 status read leaves line control", d, 32'h83);
  endtask

  task automatic t_recovery;
    logic [31:0] d, dn;
    @(negedge clk); addr = A_IIR; wdata = 32'h07; wr_en = 1'b1;
    #1 chk("R6 fifo clear pulse", {31'h0, fifo_clr}, 32'h1);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R6 fifo clear ends", {31'h0, fifo_clr}, 32'h0);
    rx_byte = 8'h5a;
    @(negedge clk); addr = A_RBR; rd_en = 1'b1;
    #1 chk("R6 receive pop pulse", {31'h0, rx_pop}, 32'h1);
    @(negedge clk); rd_en = 1'b0;
    chk("R6 receive byte", rdata, 32'h5a);
    @(negedge clk); addr = A_RBR; wdata = 32'hc3; wr_en = 1'b1;
    #1 chk("R6 transmit push", {23'h0, tx_push, tx_data}, {23'h0, 1'b1, 8'hc3});
    @(negedge clk); wr_en = 1'b0;
    busy = 1'b0;
    bus_wr(A_LCR, 32'h03);
    bus_rd(A_LCR, d, dn);
    chk("R4 rewrite after idle", d, 32'h03);
    chk("R6 no busy-detect after recovery", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] d, dn;
    rx_avail = 1'b1; tx_empty = 1'b1;
    bus_wr(A_IER, 32'h03);
    bus_rd(A_IIR, d, dn);
    chk("R5 received data first", d & 32'hf, 32'h4);
    rx_avail = 1'b0;
    bus_rd(A_IIR, d, dn);
    chk("R5 transmit empty next", d & 32'hf, 32'h2);
    bus_wr(A_IER, 32'h00);
    chk("R5 irq low with none", {31'h0, irq}, 32'h0);
    busy = 1'b1;
    bus_wr(A_LCR, 32'h1f);
    bus_wr(A_IER, 32'h02);
    bus_rd(A_IIR, d, dn);
    chk("R5 transmit over busy-detect", d & 32'hf, 32'h2);
    bus_wr(A_IER, 32'h00);
    bus_rd(A_IIR, d, dn);
    chk("R5 busy-detect when alone", d & 32'hf, 32'h7);
    bus_rd(A_USR, d, dn);
    busy = 1'b0;
    bus_rd(A_USR, d, dn);
    chk("R3 status shows idle", d, 32'h0);
    tx_empty = 1'b0;
  endtask

  task automatic t_words;
    logic [31:0] d, dn;
    logic [31:0] cap_exp;
    cap_exp = (32'd4 << 16) | (32'd1 << 13) | (32'd1 << 12) | (32'd1 << 11)
            | (32'd1 << 10) | (32'd1 << 8) | (32'd1 << 5) | (32'd1 << 4) | 32'd2;
    bus_rd(A_CAP, d, dn);
    chk("R7 capability word", d, cap_exp);
    chk("R8 capability zero without extras", dn, 32'h0);
    bus_rd(A_VER, d, dn);
    chk("R8 version word", d, 32'h3430_312a);
    chk("R8 version zero without extras", dn, 32'h0);
  endtask

  task automatic t_msr;
    logic [31:0] d, dn;
    modem_in = 4'h1;
    @(negedge clk);
    bus_rd(A_MSR, d, dn);
    chk("R9 cts and change", d & 32'h11, 32'h11);
    bus_rd(A_MSR, d, dn);
    chk("R9 change cleared by read", d & 32'h11, 32'h10);
    modem_in = 4'h0;
    bus_wr(A_MCR, 32'h20);
    bus_rd(A_MSR, d, dn);
    chk("R9 auto flow forces cts", d & 32'h11, 32'h10);
    bus_wr(A_MCR, 32'h00);
    bus_rd(A_MSR, d, dn);
    chk("R9 raw cts after auto flow off", d & 32'h11, 32'h00);
  endtask

  task automatic t_shift;
    logic [31:0] d, dn;
    bus_wr(8'h0d, 32'h55);
    bus_rd(8'h0d, d, dn);
    chk("R10 unaligned read zero", d, 32'h0);
    bus_wr(8'h03, 32'h1e);
    bus_rd(A_LCR, d, dn);
    chk("R10 unaligned write ignored", d, 32'h03);
    bus_rd(8'h03, d, dn);
    chk("R10 zero shift decodes index 3", dn, 32'h1e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_write();
    t_busy_write();
    t_usr_clear();
    t_recovery();
    t_prio();
    t_words();
    t_msr();
    t_shift();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule